// File: doc/BRIEF.md
# Seconds Counter Timer with Match Alarms

This block is a memory-mapped seconds timer. It keeps a 32-bit count that rises by one on every one-second tick pulse, together with a companion count that falls by one on the same tick. Once both are loaded to complementary values, the two stay complementary. Two compare registers are checked against the rising count on every tick. A hit is latched in a status register, which software clears by writing ones. The latched hits drive a level interrupt and a wake output.

A control register sets several things: it can halt counting so that software can load the counts, it can hold both counts in their cleared state, and it selects which hits reach the interrupt and which reach the wake output. A separate force bit drives the wake output high directly. A 32-bit scratch key register is cleared only by the power-up reset, so software can use it to tell a first power-up from a later system reset.

The register port is a single-cycle interface. A write takes effect on the clock edge where it is presented, and read data is a combinational function of the address. The tick input is a one-clock pulse in the block's clock domain.

Top module: `rtc_sec_timer`

## Requirements
- R1: After reset, the following read values hold: up count (0x00) = 0, down count (0x04) = 0xFFFFFFFF, both compare registers (0x08, 0x0C) = 0xFFFFFFFF, control (0x10) = 0, status (0x14) = 0. The irq and wake pins are low.
- R2: While control bit 6 (halt) and bit 4 (hold-clear) are both 0, each tick adds 1 to the up count and subtracts 1 from the down count. Both new values are readable from the clock edge that samples the tick.
- R3: While halt (bit 6) is 1, ticks do not change either count, and writes to 0x00 and 0x04 load the up and down counts. While halt is 0, writes to those offsets are ignored.
- R4: While control bit 4 is 1, the up count is held at 0 and the down count at 0xFFFFFFFF. Ticks are ignored for counting and for matching.
- R5: On a tick with bit 4 clear, status bit 0 (or bit 1) is set if the up count equals compare register 0 (or 1). This happens on every such tick, even while halted. Without a tick, no status bit becomes set.
- R6: Writing 0x14 clears each status bit whose write-data bit is 1 and leaves the others alone. A status bit can never be set by a write. If a new hit and a clear fall on the same edge, the hit wins.
- R7: The irq pin is a registered level, high one cycle after (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1) becomes true, and low one cycle after it becomes false.
- R8: The wake pin is a registered level, high one cycle after control bit 7 is set, or after (status bit 0 AND control bit 2) OR (status bit 1 AND control bit 3) holds. Status bit 2 is set on the same edge as a hit whose wake enable (bit 2 for compare 0, bit 3 for compare 1) is 1. The force bit alone never sets status bit 2.
- R9: The key register at 0x18 reads back the last 32-bit value written to it. The system reset (rst_n) leaves it unchanged, and only the power-up reset (por_n) clears it to 0.
- R10: Control bit 5 always reads 0. Offsets other than 0x00-0x18 in steps of 4 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| por_n | input | 1 | Power-up reset, active low; also clears the key |
| tick | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level alarm interrupt |
| wake | output | 1 | Level wake / power-on request |

## Verification
Two kinds of internal fault show up at the ports. A count that is wrong or that drifts shows on the very next read of 0x00 or 0x04. A loss of complement shows as a down count that does not match 0xFFFFFFFF minus the up count after a tick. A status bit latched wrongly or cleared wrongly shows at 0x14 at once, and it shows at irq or wake exactly one clock later, because both pins are registered from the latched bits. Faults in the reset domains show only across a reset: a key that is lost on rst_n, or a count that survives por_n, is caught by reading after each kind of reset.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned STAT_W    = 3;
  localparam int unsigned NUM_CMP   = 2;

  // register byte offsets
  localparam logic [7:0] OFS_UP    = 8'h00;
  localparam logic [7:0] OFS_DN    = 8'h04;
  localparam logic [7:0] OFS_CMP0  = 8'h08;
  localparam logic [7:0] OFS_CMP1  = 8'h0C;
  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h14;
  localparam logic [7:0] OFS_KEY   = 8'h18;

  // control bit positions
  localparam int unsigned CB_IRQ_EN0  = 0;
  localparam int unsigned CB_IRQ_EN1  = 1;
  localparam int unsigned CB_WAKE_EN0 = 2;
  localparam int unsigned CB_WAKE_EN1 = 3;
  localparam int unsigned CB_HOLD_CLR = 4;
  localparam int unsigned CB_HALT     = 6;
  localparam int unsigned CB_FORCE    = 7;

  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'hDF;

  // status bit positions
  localparam int unsigned SB_WAKE = 2;

  typedef logic [CTRL_W-1:0] rtc_ctrl_t;
  typedef logic [STAT_W-1:0] rtc_stat_t;

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_cnt_pair.sv
module rtc_cnt_pair #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         halt,
  input  logic         hold_clr,
  input  logic         ld_up,
  input  logic         ld_dn,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] up_o,
  output logic [W-1:0] dn_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] up_q, up_d;
  logic [W-1:0] dn_q, dn_d;
  logic         up_en, dn_en;

  always_comb begin
    up_d  = up_q;
    dn_d  = dn_q;
    up_en = 1'b0;
    dn_en = 1'b0;
    if (hold_clr) begin
      up_d  = '0;
      dn_d  = '1;
      up_en = 1'b1;
      dn_en = 1'b1;
    end else if (halt) begin
      if (ld_up) begin
        up_d  = ld_val;
        up_en = 1'b1;
      end
      if (ld_dn) begin
        dn_d  = ld_val;
        dn_en = 1'b1;
      end
    end else if (tick) begin
      up_d  = up_q + ONE;
      dn_d  = dn_q - ONE;
      up_en = 1'b1;
      dn_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     up_q <= '0;
    else if (up_en) up_q <= up_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dn_q <= '1;
    else if (dn_en) dn_q <= dn_d;
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/rtc_match_unit.sv
module rtc_match_unit
  import rtc_sec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_ok,
  input  logic [W-1:0]                up_cnt,
  input  logic [NUM_CMP-1:0][W-1:0]   cmp_val,
  input  logic [NUM_CMP-1:0]          irq_en,
  input  logic [NUM_CMP-1:0]          wake_en,
  input  logic                        wake_force,
  input  logic                        clr_we,
  input  rtc_stat_t                   clr_mask,
  output rtc_stat_t                   status_o,
  output logic                        irq_o,
  output logic                        wake_o
);
  logic [NUM_CMP-1:0] hit;
  rtc_stat_t          stat_q, stat_d;
  logic               stat_en;
  logic               irq_q, irq_d;
  logic               wake_q, wake_d;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign hit[i] = tick_ok && (up_cnt == cmp_val[i]);
  end

  always_comb begin
    stat_d = stat_q;
    if (clr_we) stat_d = stat_d & ~clr_mask;
    stat_d[NUM_CMP-1:0] = stat_d[NUM_CMP-1:0] | hit;
    stat_d[SB_WAKE]     = stat_d[SB_WAKE] | (|(hit & wake_en));
    stat_en = clr_we | (|hit);
    irq_d   = |(stat_q[NUM_CMP-1:0] & irq_en);
    wake_d  = wake_force | (|(stat_q[NUM_CMP-1:0] & wake_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      wake_q <= wake_d;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = irq_q;
  assign wake_o   = wake_q;
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_sec_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      por_rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [W-1:0]              bus_wdata,
  input  logic [W-1:0]              up_cnt,
  input  logic [W-1:0]              dn_cnt,
  input  rtc_stat_t                 status,
  output rtc_ctrl_t                 ctrl_o,
  output logic [NUM_CMP-1:0][W-1:0] cmp_o,
  output logic [W-1:0]              key_o,
  output logic                      ld_up,
  output logic                      ld_dn,
  output logic                      clr_we,
  output logic [W-1:0]              bus_rdata
);
  rtc_ctrl_t                 ctrl_q, ctrl_d;
  logic [NUM_CMP-1:0][W-1:0] cmp_q;
  logic [W-1:0]              key_q;
  logic                      ctrl_we, key_we;
  logic [NUM_CMP-1:0]        cmp_we;

  assign ctrl_we   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign key_we    = bus_wr && (bus_addr == ADDR_W'(OFS_KEY));
  assign ld_up     = bus_wr && (bus_addr == ADDR_W'(OFS_UP));
  assign ld_dn     = bus_wr && (bus_addr == ADDR_W'(OFS_DN));
  assign clr_we    = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign cmp_we[0] = bus_wr && (bus_addr == ADDR_W'(OFS_CMP0));
  assign cmp_we[1] = bus_wr && (bus_addr == ADDR_W'(OFS_CMP1));

  always_comb begin
    ctrl_d = bus_wdata[CTRL_W-1:0] & CTRL_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q[i] <= '1;
      else if (cmp_we[i]) cmp_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n)  key_q <= '0;
    else if (key_we) key_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == ADDR_W'(OFS_UP))   bus_rdata = up_cnt;
    else if (bus_addr == ADDR_W'(OFS_DN))   bus_rdata = dn_cnt;
    else if (bus_addr == ADDR_W'(OFS_CMP0)) bus_rdata = cmp_q[0];
    else if (bus_addr == ADDR_W'(OFS_CMP1)) bus_rdata = cmp_q[1];
    else if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = W'(ctrl_q);
    else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = W'(status);
    else if (bus_addr == ADDR_W'(OFS_KEY))  bus_rdata = key_q;
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;
  assign key_o  = key_q;
endmodule

// File: rtl/rtc_sec_timer.sv
module rtc_sec_timer
  import rtc_sec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wake
);
  logic                           core_arst_n;
  logic                           core_rst_n;
  logic                           por_rst_n;
  rtc_ctrl_t                      ctrl;
  rtc_stat_t                      status;
  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_val;
  logic [DATA_W-1:0]              key_val;
  logic [DATA_W-1:0]              cnt_up, cnt_dn;
  logic                           ld_up, ld_dn, clr_we;
  logic                           tick_ok;

  assign core_arst_n = rst_n & por_n;

  rtc_rst_sync #(.STAGES(2)) u_core_rst (
    .clk    (clk),
    .arst_n (core_arst_n),
    .rst_n_o(core_rst_n)
  );

  rtc_rst_sync #(.STAGES(2)) u_por_rst (
    .clk    (clk),
    .arst_n (por_n),
    .rst_n_o(por_rst_n)
  );

  rtc_regbank #(.W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .por_rst_n(por_rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .up_cnt   (cnt_up),
    .dn_cnt   (cnt_dn),
    .status   (status),
    .ctrl_o   (ctrl),
    .cmp_o    (cmp_val),
    .key_o    (key_val),
    .ld_up    (ld_up),
    .ld_dn    (ld_dn),
    .clr_we   (clr_we),
    .bus_rdata(bus_rdata)
  );

  rtc_cnt_pair #(.W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (tick),
    .halt    (ctrl[CB_HALT]),
    .hold_clr(ctrl[CB_HOLD_CLR]),
    .ld_up   (ld_up),
    .ld_dn   (ld_dn),
    .ld_val  (bus_wdata),
    .up_o    (cnt_up),
    .dn_o    (cnt_dn)
  );

  assign tick_ok = tick & ~ctrl[CB_HOLD_CLR];

  rtc_match_unit #(.W(DATA_W)) u_match (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick_ok   (tick_ok),
    .up_cnt    (cnt_up),
    .cmp_val   (cmp_val),
    .irq_en    ({ctrl[CB_IRQ_EN1], ctrl[CB_IRQ_EN0]}),
    .wake_en   ({ctrl[CB_WAKE_EN1], ctrl[CB_WAKE_EN0]}),
    .wake_force(ctrl[CB_FORCE]),
    .clr_we    (clr_we),
    .clr_mask  (bus_wdata[STAT_W-1:0]),
    .status_o  (status),
    .irq_o     (irq),
    .wake_o    (wake)
  );
endmodule

// File: rtl/rtc_sec_timer_chk.sv
module rtc_sec_timer_chk
  import rtc_sec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              por_ok,
  input logic              tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt_up,
  input logic [DATA_W-1:0] cnt_dn,
  input rtc_ctrl_t         ctrl,
  input rtc_stat_t         status,
  input logic [DATA_W-1:0] key_val,
  input logic              irq
);
  logic cnt_wr, stat0_clr, key_wr;
  assign cnt_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_UP) || bus_addr == ADDR_W'(OFS_DN));
  assign stat0_clr = bus_wr && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[0];
  assign key_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_KEY));

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && !ctrl[CB_HALT] && !ctrl[CB_HOLD_CLR]) |=> (cnt_up == $past(cnt_up) + DATA_W'(1))); // R2
  AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && !ctrl[CB_HALT] && !ctrl[CB_HOLD_CLR]) |=> (cnt_dn == $past(cnt_dn) - DATA_W'(1))); // R2
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctrl[CB_HALT] && !ctrl[CB_HOLD_CLR] && !cnt_wr) |=> $stable(cnt_up)); // R3
  AST_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ctrl[CB_HALT] && !ctrl[CB_HOLD_CLR] && !tick) |=> ($stable(cnt_up) && $stable(cnt_dn))); // R3
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok)
    ctrl[CB_HOLD_CLR] |=> (cnt_up == '0 && cnt_dn == '1)); // R4
  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_ok)
    !tick |=> ((status[1:0] & ~$past(status[1:0])) == 2'b00)); // R5
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_ok)
    (status[0] && !stat0_clr) |=> status[0]); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ok)
    irq |-> $past(ctrl[CB_IRQ_EN1:CB_IRQ_EN0] != 2'b00)); // R7
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!por_ok)
    !key_wr |=> $stable(key_val)); // R9
endmodule

bind rtc_sec_timer rtc_sec_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_ok   (core_rst_n),
  .por_ok   (por_rst_n),
  .tick     (tick),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cnt_up   (cnt_up),
  .cnt_dn   (cnt_dn),
  .ctrl     (ctrl),
  .status   (status),
  .key_val  (key_val),
  .irq      (irq)
);

// File: tb/sim_rtc_sec_timer.sv
`timescale 1ns/1ps
module sim_rtc_sec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    int          kind;   // 0 register read, 1 irq pin, 2 wake pin
    logic [7:0]  addr;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;

  always #10 clk = ~clk;

  rtc_sec_timer u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
  );

  // monitor: pop expected items and compare against the ports
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        if (it.kind == 0)      act = bus_rdata;
        else if (it.kind == 1) act = {31'b0, irq};
        else                   act = {31'b0, wake};
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                   it.req, it.kind, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [7:0] a,
                             input logic [31:0] e, input string req);
    sb_item_t it;
    bus_addr = a;
    #1;
    it.kind = kind; it.addr = a; it.exp = e; it.req = req;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    expect_item(0, a, e, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(8'h00, 32'h0, "R1");
    rd(8'h04, 32'hFFFF_FFFF, "R1");
    rd(8'h08, 32'hFFFF_FFFF, "R1");
    rd(8'h0C, 32'hFFFF_FFFF, "R1");
    rd(8'h10, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    expect_item(1, 8'h00, 32'h0, "R1");
    expect_item(2, 8'h00, 32'h0, "R1");
    rd(8'h18, 32'h0, "R9");

    // R2 counting
    pulse_tick(); pulse_tick(); pulse_tick();
    rd(8'h00, 32'd3, "R2");
    rd(8'h04, 32'hFFFF_FFFC, "R2");

    // R3 load ignored while running, allowed while halted
    wr(8'h00, 32'd100);
    rd(8'h00, 32'd3, "R3");
    wr(8'h10, 32'h40);
    pulse_tick();
    rd(8'h00, 32'd3, "R3");
    wr(8'h00, 32'h10);
    wr(8'h04, 32'hFFFF_FFEF);
    rd(8'h00, 32'h10, "R3");
    rd(8'h04, 32'hFFFF_FFEF, "R3");

    // R5 match while halted repeats on every tick
    wr(8'h08, 32'h10);
    rd(8'h14, 32'h0, "R5");
    pulse_tick();
    rd(8'h14, 32'h1, "R5");
    expect_item(1, 8'h00, 32'h0, "R7");
    wr(8'h14, 32'h1);
    rd(8'h14, 32'h0, "R6");
    pulse_tick();
    rd(8'h14, 32'h1, "R5");
    wr(8'h14, 32'h1);

    // R7 irq latency with enable
    wr(8'h10, 32'h01);
    pulse_tick();
    rd(8'h00, 32'h11, "R2");
    rd(8'h14, 32'h1, "R5");
    expect_item(1, 8'h00, 32'h0, "R7");
    idle(1);
    expect_item(1, 8'h00, 32'h1, "R7");
    wr(8'h14, 32'h0);
    rd(8'h14, 32'h1, "R6");
    wr(8'h14, 32'h1);
    rd(8'h14, 32'h0, "R6");
    expect_item(1, 8'h00, 32'h1, "R7");
    idle(1);
    expect_item(1, 8'h00, 32'h0, "R7");

    // R8 wake via compare 1 and latched wake status
    wr(8'h10, 32'h48);
    wr(8'h0C, 32'h11);
    pulse_tick();
    rd(8'h14, 32'h6, "R8");
    expect_item(2, 8'h00, 32'h0, "R8");
    idle(1);
    expect_item(2, 8'h00, 32'h1, "R8");
    expect_item(1, 8'h00, 32'h0, "R7");
    wr(8'h14, 32'h7);
    rd(8'h14, 32'h0, "R6");
    idle(1);
    expect_item(2, 8'h00, 32'h0, "R8");

    // R8 force bit drives wake without latching
    wr(8'h10, 32'h80);
    idle(1);
    expect_item(2, 8'h00, 32'h1, "R8");
    rd(8'h14, 32'h0, "R8");
    wr(8'h10, 32'h00);
    idle(1);
    expect_item(2, 8'h00, 32'h0, "R8");

    // R4 hold-clear
    wr(8'h10, 32'h10);
    pulse_tick();
    pulse_tick();
    rd(8'h00, 32'h0, "R4");
    rd(8'h04, 32'hFFFF_FFFF, "R4");
    rd(8'h14, 32'h0, "R4");
    wr(8'h10, 32'h00);
    pulse_tick();
    rd(8'h00, 32'h1, "R2");
    rd(8'h04, 32'hFFFF_FFFE, "R2");

    // R10 unused offsets and reserved control bit
    wr(8'h18, 32'hB5C1_3F27);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, 32'h0, "R10");
    rd(8'h80, 32'h0, "R10");
    rd(8'h18, 32'hB5C1_3F27, "R10");
    rd(8'h10, 32'h0, "R10");
    wr(8'h10, 32'hFF);
    rd(8'h10, 32'hDF, "R10");
    wr(8'h10, 32'h00);

    // R9 key survives system reset, cleared by power-up reset
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    rd(8'h18, 32'hB5C1_3F27, "R9");
    rd(8'h00, 32'h0, "R1");
    rd(8'h08, 32'hFFFF_FFFF, "R1");
    @(negedge clk); por_n = 1'b0;
    idle(3);
    por_n = 1'b1;
    idle(4);
    rd(8'h18, 32'h0, "R9");

    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule